// File: doc/BRIEF.md
# EEPROM Image Checksum Engine

This block proves or repairs the 16-bit additive checksum that protects an EEPROM word image. It walks the image through a one-word-at-a-time read port, keeps a wrapped 16-bit running total, and compares that total against a fixed non-zero signature. The default signature is 0xBABA. The image's last protected word, the checksum word, sits at a parameterised index that defaults to 0x3F.

In check mode the engine adds every word from index 0 up to and including the checksum word. It reports pass only when the total equals the signature. In repair mode it adds only the words below the checksum word. It then writes back the one value that brings the total to the signature: the signature minus the partial total, modulo 2^16. That value goes through a word-write port. A failed read or a failed write ends the operation at once with a fail result. Each operation closes with a single-cycle completion pulse and a pass/fail flag.

Top module: `ckeng_top`

## Requirements
- R1: With op_mode_i = 0 (check), the engine reads indices 0 through CSUM_IDX inclusive. Reads go in ascending order, one outstanding request at a time.
- R2: In check mode, if the wrapped 16-bit sum of those words equals SIGNATURE, op_done_o pulses with op_pass_o = 1 and no write is issued.
- R3: In check mode, any other sum gives op_done_o with op_pass_o = 0.
- R4: With op_mode_i = 1 (repair), the engine reads only indices 0 through CSUM_IDX-1 and never requests the checksum word.
- R5: In repair mode, the engine writes (SIGNATURE - partial sum) mod 2^16 to address CSUM_IDX. An acknowledged write ends with op_pass_o = 1.
- R6: A read error (rd_err_i with rd_req_o) ends the operation with op_pass_o = 0. No further read and no write follow it.
- R7: A write error (wr_err_i with wr_req_o) ends the operation with op_pass_o = 0.
- R8: rd_req_o and rd_addr_o hold steady until a response arrives. The index advances by one only after an accepted rd_valid_i.
- R9: A start request while busy_o is high is ignored. The running operation continues in its original mode and completes exactly once.
- R10: After reset, all request, busy, done and pass outputs are low. op_done_o lasts one cycle. op_pass_o keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | Start request, sampled only while idle |
| op_mode_i | input | 1 | 0 = check, 1 = repair |
| rd_req_o | output | 1 | Word read request, held until response |
| rd_addr_o | output | ADDR_W | Word index being read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read data word |
| rd_err_i | input | 1 | Read failed |
| wr_req_o | output | 1 | Word write request, held until response |
| wr_addr_o | output | ADDR_W | Write index (always CSUM_IDX) |
| wr_data_o | output | 16 | Computed checksum word |
| wr_ack_i | input | 1 | Write completed |
| wr_err_i | input | 1 | Write failed |
| busy_o | output | 1 | Operation in progress |
| op_done_o | output | 1 | One-cycle completion pulse |
| op_pass_o | output | 1 | Result of the last operation |

## Verification
On every cycle, the assertions check the handshake discipline of both ports. A pending read keeps its address. An accepted read steps the index by exactly one. Repair mode never addresses the checksum word, and writes only ever target it with stable data. A read error is followed by a failing completion, completion pulses never stretch, and a start while busy leaves the latched mode alone. The arithmetic can only be shown by the bench's scenarios, under response latencies of 0 to 3 cycles: a wrapped sum matching or missing the signature, the exact repair value, and a repaired image then passing a check. The same holds for the exact read counts after an error and for memory left untouched when a write fails.

// File: rtl/ckeng_pkg.sv
package ckeng_pkg;
  localparam int CK_W = 16;
  typedef logic [CK_W-1:0] ck_word_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ckeng_state_e;

  // wrapped running-total step
  function automatic ck_word_t csum_add(input ck_word_t acc, input ck_word_t word);
    return acc + word;
  endfunction

  // value that brings a partial total to the signature
  function automatic ck_word_t csum_fill(input ck_word_t sig, input ck_word_t part);
    return sig - part;
  endfunction
endpackage

// File: rtl/ckeng_accum.sv
module ckeng_accum
  import ckeng_pkg::*;
#(
  parameter ck_word_t SIGNATURE = 16'hBABA
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     add_i,
  input  ck_word_t data_i,
  output logic     sum_ok_o,
  output ck_word_t fill_o
);
  ck_word_t acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= csum_add(acc_q, data_i);
  end

  // total including the word presented this cycle
  assign sum_ok_o = (csum_add(acc_q, data_i) == SIGNATURE);
  assign fill_o   = csum_fill(SIGNATURE, acc_q);

  AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_q == '0) else $error("accumulator not cleared"); // R2
endmodule

// File: rtl/ckeng_walk.sv
module ckeng_walk
  import ckeng_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CSUM_IDX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              rd_valid_i,
  input  logic              rd_err_i,
  input  logic              wr_ack_i,
  input  logic              wr_err_i,
  input  logic              sum_ok_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_req_o,
  output logic              clr_o,
  output logic              add_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);
  localparam logic [ADDR_W-1:0] CK_ADDR  = ADDR_W'(CSUM_IDX);
  localparam logic [ADDR_W-1:0] PRE_LAST = ADDR_W'((CSUM_IDX > 0) ? CSUM_IDX - 1 : 0);
  localparam logic              HAS_PRE  = (CSUM_IDX > 0);

  ckeng_state_e      st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              upd_q, upd_d;
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic [ADDR_W-1:0] last_idx;

  // named events, shared by the next-state logic and the assertions
  logic evt_start, evt_rd_ok, evt_rd_bad, evt_last, evt_wr_ok, evt_wr_bad;
  assign last_idx   = upd_q ? PRE_LAST : CK_ADDR;
  assign evt_start  = (st_q == ST_IDLE)  && start_i;
  assign evt_rd_bad = (st_q == ST_READ)  && rd_err_i;
  assign evt_rd_ok  = (st_q == ST_READ)  && rd_valid_i && !rd_err_i;
  assign evt_last   = evt_rd_ok && (idx_q == last_idx);
  assign evt_wr_bad = (st_q == ST_WRITE) && wr_err_i;
  assign evt_wr_ok  = (st_q == ST_WRITE) && wr_ack_i && !wr_err_i;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    upd_d  = upd_q;
    pass_d = pass_q;
    done_d = 1'b0;
    if (evt_start) begin
      upd_d  = mode_i;
      idx_d  = '0;
      pass_d = 1'b0;
      st_d   = (mode_i && !HAS_PRE) ? ST_WRITE : ST_READ;
    end else if (evt_rd_bad || evt_wr_bad) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      pass_d = 1'b0;
    end else if (evt_wr_ok) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      pass_d = 1'b1;
    end else if (evt_last) begin
      if (upd_q) begin
        st_d = ST_WRITE;
      end else begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        pass_d = sum_ok_i;
      end
    end else if (evt_rd_ok) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      upd_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      upd_q  <= upd_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign rd_req_o  = (st_q == ST_READ);
  assign rd_addr_o = idx_q;
  assign wr_req_o  = (st_q == ST_WRITE);
  assign clr_o     = evt_start;
  assign add_o     = evt_rd_ok;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;

  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_addr_o <= CK_ADDR) else $error("read beyond checksum word"); // R1
  AST_REPAIR_SKIPS_CK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && upd_q) |-> rd_addr_o != CK_ADDR) else $error("repair read checksum word"); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i && !rd_err_i) |=> rd_req_o && $stable(rd_addr_o)) else $error("read request dropped"); // R8
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_ok && !evt_last) |=> rd_req_o && rd_addr_o == $past(rd_addr_o) + 1'b1) else $error("bad index step"); // R8
  AST_RD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_err_i) |=> done_o && !pass_o && !rd_req_o && !wr_req_o) else $error("read error not fatal"); // R6
  AST_WR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_err_i) |=> done_o && !pass_o) else $error("write error not fatal"); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(upd_q)) else $error("start taken while busy"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done stretched"); // R10
endmodule

// File: rtl/ckeng_top.sv
module ckeng_top
  import ckeng_pkg::*;
#(
  parameter int       ADDR_W    = 8,
  parameter int       CSUM_IDX  = 63,
  parameter ck_word_t SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start_i,
  input  logic              op_mode_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [15:0]       rd_data_i,
  input  logic              rd_err_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  input  logic              wr_ack_i,
  input  logic              wr_err_i,
  output logic              busy_o,
  output logic              op_done_o,
  output logic              op_pass_o
);
  localparam logic [ADDR_W-1:0] CK_ADDR = ADDR_W'(CSUM_IDX);

  logic     clr_w, add_w, sum_ok_w;
  ck_word_t fill_w;

  ckeng_walk #(.ADDR_W(ADDR_W), .CSUM_IDX(CSUM_IDX)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start_i(op_start_i), .mode_i(op_mode_i),
    .rd_valid_i(rd_valid_i), .rd_err_i(rd_err_i),
    .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i),
    .sum_ok_i(sum_ok_w),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .wr_req_o(wr_req_o),
    .clr_o(clr_w), .add_o(add_w),
    .busy_o(busy_o), .done_o(op_done_o), .pass_o(op_pass_o)
  );

  ckeng_accum #(.SIGNATURE(SIGNATURE)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .clr_i(clr_w), .add_i(add_w), .data_i(rd_data_i),
    .sum_ok_o(sum_ok_w), .fill_o(fill_w)
  );

  assign wr_addr_o = CK_ADDR;
  assign wr_data_o = fill_w;

  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> wr_addr_o == CK_ADDR) else $error("write to wrong index"); // R5
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i && !wr_err_i) |=> wr_req_o && $stable(wr_data_o)) else $error("write data moved"); // R5
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o)) else $error("read and write together"); // R8
endmodule

// File: tb/tb_ckeng_top.sv
module tb_ckeng_top;
  localparam int ADDR_W = 8;
  localparam int CK     = 63;
  localparam logic [15:0] SIG = 16'hBABA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic op_start_i = 0, op_mode_i = 0;
  logic rd_valid_i = 0, rd_err_i = 0, wr_ack_i = 0, wr_err_i = 0;
  logic [15:0] rd_data_i = '0;
  logic rd_req_o, wr_req_o, busy_o, op_done_o, op_pass_o;
  logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
  logic [15:0] wr_data_o;

  ckeng_top #(.ADDR_W(ADDR_W), .CSUM_IDX(CK), .SIGNATURE(SIG)) dut (
    .clk(clk), .rst_n(rst_n), .op_start_i(op_start_i), .op_mode_i(op_mode_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i),
    .busy_o(busy_o), .op_done_o(op_done_o), .op_pass_o(op_pass_o)
  );

  logic [15:0] mem [256];
  int lat = 0, rd_wait = 0, wr_wait = 0, err_rd_at = -1;
  bit err_wr = 0;
  int n_rd, n_wr, n_done, exp_addr, max_addr, wr_addr_seen;
  logic [15:0] wr_seen;
  bit pass_seen, addr_bad, pulse_bad, prev_done;
  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_upto(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic fill_image(input logic [15:0] seed);
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1357 + seed);
  endtask

  // responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (op_done_o) begin
      n_done++;
      pass_seen = op_pass_o;
      if (prev_done) pulse_bad = 1;
    end
    prev_done = op_done_o;
    rd_valid_i = 0; rd_err_i = 0; wr_ack_i = 0; wr_err_i = 0; rd_data_i = '0;
    if (rd_req_o) begin
      if (rd_wait < lat) rd_wait++;
      else begin
        rd_wait = 0;
        if (int'(rd_addr_o) != exp_addr) addr_bad = 1;
        exp_addr++;
        n_rd++;
        if (int'(rd_addr_o) > max_addr) max_addr = int'(rd_addr_o);
        if (int'(rd_addr_o) == err_rd_at) rd_err_i = 1;
        else begin rd_valid_i = 1; rd_data_i = mem[rd_addr_o]; end
      end
    end else rd_wait = 0;
    if (wr_req_o) begin
      if (wr_wait < lat) wr_wait++;
      else begin
        wr_wait = 0;
        n_wr++;
        wr_seen = wr_data_o;
        wr_addr_seen = int'(wr_addr_o);
        if (err_wr) wr_err_i = 1;
        else begin wr_ack_i = 1; mem[wr_addr_o] = wr_data_o; end
      end
    end else wr_wait = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic clear_stats();
    n_rd = 0; n_wr = 0; n_done = 0; exp_addr = 0; max_addr = -1;
    addr_bad = 0; pulse_bad = 0; wr_seen = '0; wr_addr_seen = -1;
  endtask

  task automatic run_op(input logic mode);
    clear_stats();
    @(negedge clk);
    op_start_i = 1; op_mode_i = mode;
    @(negedge clk);
    op_start_i = 0;
    while (n_done == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!rd_req_o && !wr_req_o && !busy_o && !op_done_o && !op_pass_o, "R10 reset outputs",
        {rd_req_o, wr_req_o, busy_o, op_done_o, op_pass_o}, 0);
  endtask

  task automatic t_check_good(input int l);
    lat = l; err_rd_at = -1; err_wr = 0;
    fill_image(16'h0101 + 16'(l));
    mem[CK] = SIG - sum_upto(CK - 1);
    run_op(1'b0);
    chk(n_rd == CK + 1 && !addr_bad, "R1 check reads 0..CK in order", n_rd, CK + 1);
    chk(n_done == 1 && pass_seen && n_wr == 0, "R2 good image passes", pass_seen, 1);
    chk(!pulse_bad, "R10 done single cycle", pulse_bad, 0);
    chk(op_pass_o == 1'b1, "R10 pass held after done", op_pass_o, 1);
  endtask

  task automatic t_check_bad();
    lat = 1; err_rd_at = -1; err_wr = 0;
    fill_image(16'h2222);
    mem[CK] = SIG - sum_upto(CK - 1);
    mem[10] = mem[10] ^ 16'h0040;
    run_op(1'b0);
    chk(n_done == 1 && !pass_seen, "R3 corrupted image fails", pass_seen, 0);
    chk(n_rd == CK + 1 && n_wr == 0, "R3 full walk without write", n_rd, CK + 1);
  endtask

  task automatic t_repair(input int l);
    logic [15:0] exp_fill;
    lat = l; err_rd_at = -1; err_wr = 0;
    fill_image(16'hF00D + 16'(l));
    exp_fill = SIG - sum_upto(CK - 1);
    run_op(1'b1);
    chk(max_addr == CK - 1 && n_rd == CK && !addr_bad, "R4 repair skips checksum word", max_addr, CK - 1);
    chk(n_wr == 1 && wr_addr_seen == CK, "R5 write to checksum index", wr_addr_seen, CK);
    chk(wr_seen == exp_fill, "R5 repair value", wr_seen, exp_fill);
    chk(n_done == 1 && pass_seen, "R5 repair passes", pass_seen, 1);
    run_op(1'b0);
    chk(pass_seen, "R5 repaired image then checks good", pass_seen, 1);
  endtask

  task automatic t_read_error(input logic mode, input int at);
    lat = 2; err_rd_at = at; err_wr = 0;
    fill_image(16'h0303);
    run_op(mode);
    chk(n_rd == at + 1 && n_wr == 0, "R6 no access after read error", n_rd, at + 1);
    chk(n_done == 1 && !pass_seen, "R6 read error fails", pass_seen, 0);
    err_rd_at = -1;
  endtask

  task automatic t_write_error();
    logic [15:0] old;
    lat = 1; err_rd_at = -1; err_wr = 1;
    fill_image(16'h4444);
    old = mem[CK];
    run_op(1'b1);
    chk(n_done == 1 && !pass_seen && n_wr == 1, "R7 write error fails", pass_seen, 0);
    chk(mem[CK] == old, "R7 memory untouched", mem[CK], old);
    err_wr = 0;
  endtask

  task automatic t_busy_start();
    lat = 0; err_rd_at = -1; err_wr = 0;
    fill_image(16'h5555);
    mem[CK] = SIG - sum_upto(CK - 1);
    clear_stats();
    @(negedge clk); op_start_i = 1; op_mode_i = 0;
    @(negedge clk); op_start_i = 0;
    repeat (6) @(negedge clk);
    op_start_i = 1; op_mode_i = 1;
    @(negedge clk); op_start_i = 0;
    while (n_done == 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(n_done == 1 && n_wr == 0, "R9 start while busy ignored", n_done, 1);
    chk(n_rd == CK + 1 && pass_seen, "R9 original check completes", n_rd, CK + 1);
  endtask

  initial begin
    clear_stats();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_check_good(0);
    t_check_good(3);
    t_check_bad();
    t_repair(0);
    t_repair(2);
    t_read_error(1'b0, 20);
    t_read_error(1'b1, 5);
    t_write_error();
    t_busy_start();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule